// File: doc/BRIEF.md
# Pattern-Replay SDRAM Command Sequencer

This block drives a DDR3-style command and address bus by replaying command sequences that were worked out ahead of time, instead of checking memory timing one command at a time. Each accepted request runs exactly one stored sequence. A read request runs the read sequence and a write request runs the write sequence. A sequence is a list of slots. Each slot names a command (activate, read, write, precharge or idle) and a bank offset that is added to the request's first bank. Each slot also carries a repeat count of idle cycles that follow the command. This lets one sequence interleave several banks with a fixed number of bursts per bank. The number of bytes moved per sequence is banks interleaved × bursts per bank × burst length × interface width in bytes. Each burst occupies BL/2 clock cycles of the data bus.

The sequence table is held in registers and can be rewritten through a small write-only configuration port. A rewrite that arrives while a sequence is running is held in a one-entry buffer and applied once the sequence has ended. The running sequence therefore always sees a fixed table. Within one sequence, the column address of each bank steps by BL words from one burst to the next. Requests use a valid/ready handshake, and sequences never overlap.

Top module: `sdram_pattern_seq`

## Requirements
- R1: After reset, `req_ready` and `cfg_ready` are 1. The bus shows the idle command (cs_n=0, ras_n=1, cas_n=1, we_n=1) with `ddr_ba`=0 and `ddr_addr`=0.
- R2: A request is taken only on a cycle where `req_ready` is 1. `req_ready` goes low in the cycle after acceptance. It returns high in the cycle after the last slot cycle, so consecutive sequences are separated by at least one idle cycle.
- R3: Slots run in order from slot 0 up to the programmed last slot index. A slot with repeat count n takes n+1 cycles: its command in the first cycle, then n idle commands. The command of slot 0 appears on the bus in the second cycle after the acceptance edge, that is, after the next clock edge.
- R4: The opcodes are 0 = idle, 1 = activate, 2 = read, 3 = write and 4 = precharge. Codes 5 to 7 behave as idle. On the bus, {ras_n,cas_n,we_n} is 011 for activate, 101 for read, 100 for write and 010 for precharge, with cs_n=0 throughout.
- R5: The bank of a command is (request bank + slot bank offset) modulo 2^BANK_W.
- R6: Activate puts the request row on `ddr_addr`. Precharge puts 0 there. Idle cycles drive `ddr_ba`=0 and `ddr_addr`=0.
- R7: Read and write put the column on `ddr_addr`, zero-extended. The column is (request column + n×BL) modulo 2^COL_W, where n is the number of earlier reads or writes with the same bank offset in the same sequence.
- R8: `req_write`=1 selects table 1 (write sequence). `req_write`=0 selects table 0 (read sequence).
- R9: Configuration map. When `cfg_addr[5]`=0, `cfg_addr[4]` selects the table and `cfg_addr[3:0]` selects the slot, and `cfg_wdata` is {opcode[8:6], bank offset[5:4], repeat[3:0]}. When `cfg_addr[5]`=1, `cfg_addr[0]` selects the table and `cfg_wdata[3:0]` is that table's last slot index.
- R10: A configuration write while a sequence runs does not affect that sequence. It is held with `cfg_ready` and `req_ready` low, and is applied in the first idle cycle, after which both return to 1.
- R11: After reset every slot is idle with repeat 0 and both last slot indices are 0, so any request produces a single idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_write | input | 1 | 1 = write sequence, 0 = read sequence |
| req_bank | input | BANK_W | First bank of the request |
| req_row | input | ROW_W | Row to activate |
| req_col | input | COL_W | Starting column |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | SLOT_AW+2 | Configuration address |
| cfg_wdata | input | 3+OFS_W+REP_W | Configuration data |
| cfg_ready | output | 1 | No configuration write is being held |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BANK_W | Bank address |
| ddr_addr | output | ROW_W | Row or column address |

## Verification
The hardest case to reach is a table rewrite that lands while a sequence is in flight. The held write must leave that sequence untouched, block the next request for exactly one cycle, and then take effect. The bench fires a configuration write from inside its cycle-by-cycle comparison loop, a few cycles into a read sequence. It checks that the rest of the stream matches the old table and that both ready signals stay low for the extra cycle. It then checks that the next read shows the replaced precharge as idle. Column stepping and bank wrap-around are covered by sweeping every first bank against columns near zero and near the top of the column range, for both sequences.

// File: rtl/patseq_pkg.sv
package patseq_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_IDLE = 3'd0,
        OPC_ACT  = 3'd1,
        OPC_RD   = 3'd2,
        OPC_WR   = 3'd3,
        OPC_PRE  = 3'd4
    } opc_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobes_t;

    localparam strobes_t STB_IDLE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic strobes_t opc_strobes(logic [OPC_W-1:0] opc);
        strobes_t s;
        s = STB_IDLE;
        case (opc)
            OPC_ACT: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            OPC_RD:  s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            OPC_WR:  s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
            OPC_PRE: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            default: s = STB_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic opc_is_burst(logic [OPC_W-1:0] opc);
        return (opc == OPC_RD) || (opc == OPC_WR);
    endfunction

endpackage

// File: rtl/patseq_table.sv
module patseq_table
    import patseq_pkg::*;
#(
    parameter int SLOT_AW = 4,
    parameter int OFS_W   = 2,
    parameter int REP_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            busy,
    input  logic                            cfg_we,
    input  logic [SLOT_AW+1:0]              cfg_addr,
    input  logic [OPC_W+OFS_W+REP_W-1:0]    cfg_wdata,
    output logic                            cfg_ready,
    input  logic                            rd_sel,
    input  logic [SLOT_AW-1:0]              rd_slot,
    output logic [OPC_W+OFS_W+REP_W-1:0]    rd_entry,
    output logic [SLOT_AW-1:0]              rd_last
);
    localparam int SLOTS = 1 << SLOT_AW;
    localparam int EW    = OPC_W + OFS_W + REP_W;
    localparam int CA_W  = SLOT_AW + 2;

    logic [EW-1:0]      mem    [2][SLOTS];
    logic [SLOT_AW-1:0] last_q [2];

    logic               held_v;
    logic [CA_W-1:0]    held_a;
    logic [EW-1:0]      held_d;

    logic               wr_en;
    logic [CA_W-1:0]    wr_a;
    logic [EW-1:0]      wr_d;
    logic               take;

    assign take      = cfg_we && !held_v;
    assign cfg_ready = !held_v;

    always_comb begin
        wr_en = 1'b0;
        wr_a  = held_a;
        wr_d  = held_d;
        if (!busy) begin
            if (held_v) begin
                wr_en = 1'b1;
            end else if (take) begin
                wr_en = 1'b1;
                wr_a  = cfg_addr;
                wr_d  = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held_a <= '0;
            held_d <= '0;
        end else if (held_v && !busy) begin
            held_v <= 1'b0;
        end else if (take && busy) begin
            held_v <= 1'b1;
            held_a <= cfg_addr;
            held_d <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                last_q[p] <= '0;
                for (int s = 0; s < SLOTS; s++) begin
                    mem[p][s] <= '0;
                end
            end
        end else if (wr_en) begin
            if (!wr_a[CA_W-1]) begin
                mem[wr_a[SLOT_AW]][wr_a[SLOT_AW-1:0]] <= wr_d;
            end else begin
                last_q[wr_a[0]] <= wr_d[SLOT_AW-1:0];
            end
        end
    end

    assign rd_entry = mem[rd_sel][rd_slot];
    assign rd_last  = last_q[rd_sel];

    // R10: the table never changes under a running sequence
    a_r10_no_write_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !busy);

    // R10: a write arriving mid-sequence is parked
    a_r10_hold_parks: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_ready && busy) |=> !cfg_ready);

    // R10: a parked write is released in the first idle cycle
    a_r10_hold_drains: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ready && !busy) |=> cfg_ready);

endmodule

// File: rtl/patseq_walker.sv
module patseq_walker #(
    parameter int SLOT_AW = 4,
    parameter int REP_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [REP_W-1:0]   rep,
    input  logic [SLOT_AW-1:0] last,
    output logic               busy,
    output logic               fire,
    output logic [SLOT_AW-1:0] slot
);
    logic               run_q;
    logic [SLOT_AW-1:0] slot_q;
    logic [REP_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            slot_q <= '0;
            cnt_q  <= '0;
        end else if (!run_q) begin
            if (start) begin
                run_q  <= 1'b1;
                slot_q <= '0;
                cnt_q  <= '0;
            end
        end else if (cnt_q == rep) begin
            cnt_q <= '0;
            if (slot_q == last) begin
                run_q <= 1'b0;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy = run_q;
    assign fire = run_q && (cnt_q == '0);
    assign slot = slot_q;

    // R3: the idle-cycle counter never passes the slot's repeat count
    a_r3_rep_bound: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q <= rep));

    // R3: the slot pointer never runs past the last programmed slot
    a_r3_slot_bound: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (slot_q <= last));

    // R3: a sequence always opens at slot 0 with its command
    a_r3_opens_slot0: assert property (@(posedge clk) disable iff (rst)
        (start && !run_q) |=> (fire && slot_q == '0));

endmodule

// File: rtl/patseq_addrgen.sv
module patseq_addrgen
    import patseq_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int OFS_W  = 2,
    parameter int BL     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BANK_W-1:0]  in_bank,
    input  logic [ROW_W-1:0]   in_row,
    input  logic [COL_W-1:0]   in_col,
    input  logic               fire,
    input  logic [OPC_W-1:0]   opc,
    input  logic [OFS_W-1:0]   ofs,
    output logic [BANK_W-1:0]  out_bank,
    output logic [ROW_W-1:0]   out_row,
    output logic [COL_W-1:0]   out_col
);
    localparam int          LANES   = 1 << OFS_W;
    localparam logic [COL_W-1:0] COL_STEP = COL_W'(BL);

    logic [BANK_W-1:0] base_bank;
    logic [ROW_W-1:0]  base_row;
    logic [COL_W-1:0]  base_col;
    logic [COL_W-1:0]  lane_acc [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_bank <= '0;
            base_row  <= '0;
            base_col  <= '0;
        end else if (start) begin
            base_bank <= in_bank;
            base_row  <= in_row;
            base_col  <= in_col;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || start) begin
                lane_acc[g] <= '0;
            end else if (fire && opc_is_burst(opc) && (ofs == OFS_W'(g))) begin
                lane_acc[g] <= lane_acc[g] + COL_STEP;
            end
        end
    end

    assign out_bank = base_bank + BANK_W'(ofs);
    assign out_row  = base_row;
    assign out_col  = base_col + lane_acc[ofs];

endmodule

// File: rtl/patseq_cmdout.sv
module patseq_cmdout
    import patseq_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [OPC_W-1:0]  opc,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output strobes_t          stb,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr
);
    strobes_t          stb_d;
    logic [BANK_W-1:0] ba_d;
    logic [ROW_W-1:0]  addr_d;

    always_comb begin
        stb_d  = STB_IDLE;
        ba_d   = '0;
        addr_d = '0;
        if (fire) begin
            stb_d = opc_strobes(opc);
            case (opc)
                OPC_ACT: begin
                    ba_d   = bank;
                    addr_d = row;
                end
                OPC_RD, OPC_WR: begin
                    ba_d   = bank;
                    addr_d = ROW_W'(col);
                end
                OPC_PRE: begin
                    ba_d   = bank;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb  <= STB_IDLE;
            ba   <= '0;
            addr <= '0;
        end else begin
            stb  <= stb_d;
            ba   <= ba_d;
            addr <= addr_d;
        end
    end

    // R4: only the five legal strobe patterns ever reach the bus
    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
        !stb.cs_n && ({stb.ras_n, stb.cas_n, stb.we_n} inside {3'b111, 3'b011, 3'b101, 3'b100, 3'b010}));

    // R6: idle cycles leave bank and address at zero
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (stb == STB_IDLE) |-> (ba == '0 && addr == '0));

    // R6: precharge carries a zero address
    a_r6_pre_zero: assert property (@(posedge clk) disable iff (rst)
        ({stb.ras_n, stb.cas_n, stb.we_n} == 3'b010) |-> (addr == '0));

endmodule

// File: rtl/sdram_pattern_seq.sv
module sdram_pattern_seq
    import patseq_pkg::*;
#(
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 14,
    parameter int COL_W   = 10,
    parameter int BL      = 8,
    parameter int SLOT_AW = 4,
    parameter int OFS_W   = 2,
    parameter int REP_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [BANK_W-1:0]            req_bank,
    input  logic [ROW_W-1:0]             req_row,
    input  logic [COL_W-1:0]             req_col,
    input  logic                         cfg_we,
    input  logic [SLOT_AW+1:0]           cfg_addr,
    input  logic [OPC_W+OFS_W+REP_W-1:0] cfg_wdata,
    output logic                         cfg_ready,
    output logic                         ddr_cs_n,
    output logic                         ddr_ras_n,
    output logic                         ddr_cas_n,
    output logic                         ddr_we_n,
    output logic [BANK_W-1:0]            ddr_ba,
    output logic [ROW_W-1:0]             ddr_addr
);
    localparam int EW = OPC_W + OFS_W + REP_W;

    logic               busy;
    logic               fire;
    logic               start;
    logic               sel_q;
    logic [SLOT_AW-1:0] slot;
    logic [SLOT_AW-1:0] last;
    logic [EW-1:0]      entry;
    logic [OPC_W-1:0]   e_opc;
    logic [OFS_W-1:0]   e_ofs;
    logic [REP_W-1:0]   e_rep;
    logic [BANK_W-1:0]  g_bank;
    logic [ROW_W-1:0]   g_row;
    logic [COL_W-1:0]   g_col;
    strobes_t           stb;

    assign req_ready = !busy && cfg_ready;
    assign start     = req_valid && req_ready;

    assign e_opc = entry[EW-1 -: OPC_W];
    assign e_ofs = entry[REP_W +: OFS_W];
    assign e_rep = entry[REP_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (start) begin
            sel_q <= req_write;
        end
    end

    patseq_table #(
        .SLOT_AW (SLOT_AW),
        .OFS_W   (OFS_W),
        .REP_W   (REP_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_ready (cfg_ready),
        .rd_sel    (sel_q),
        .rd_slot   (slot),
        .rd_entry  (entry),
        .rd_last   (last)
    );

    patseq_walker #(
        .SLOT_AW (SLOT_AW),
        .REP_W   (REP_W)
    ) u_walker (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .rep   (e_rep),
        .last  (last),
        .busy  (busy),
        .fire  (fire),
        .slot  (slot)
    );

    patseq_addrgen #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .OFS_W  (OFS_W),
        .BL     (BL)
    ) u_addrgen (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_bank  (req_bank),
        .in_row   (req_row),
        .in_col   (req_col),
        .fire     (fire),
        .opc      (e_opc),
        .ofs      (e_ofs),
        .out_bank (g_bank),
        .out_row  (g_row),
        .out_col  (g_col)
    );

    patseq_cmdout #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_cmdout (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .opc  (e_opc),
        .bank (g_bank),
        .row  (g_row),
        .col  (g_col),
        .stb  (stb),
        .ba   (ddr_ba),
        .addr (ddr_addr)
    );

    assign ddr_cs_n  = stb.cs_n;
    assign ddr_ras_n = stb.ras_n;
    assign ddr_cas_n = stb.cas_n;
    assign ddr_we_n  = stb.we_n;

    // R2: an accepted request always starts a sequence on the next cycle
    a_r2_accept_runs: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R2: the cycle a sequence ends is followed by a quiet bus cycle
    a_r2_gap_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> (stb == STB_IDLE));

    // R8: the table choice is frozen while a sequence runs
    a_r8_sel_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sel_q));

endmodule

// File: tb/tb_sdram_pattern_seq.sv
module tb_sdram_pattern_seq;
    localparam int BANK_W  = 3;
    localparam int ROW_W   = 14;
    localparam int COL_W   = 10;
    localparam int BL      = 8;
    localparam int SLOT_AW = 4;
    localparam int OFS_W   = 2;
    localparam int REP_W   = 4;
    localparam int EW      = 3 + OFS_W + REP_W;
    localparam int NBANK   = 1 << BANK_W;
    localparam int NCOL    = 1 << COL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic cfg_we = 1'b0;
    logic [SLOT_AW+1:0] cfg_addr = '0;
    logic [EW-1:0] cfg_wdata = '0;
    logic cfg_ready;
    logic ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [BANK_W-1:0] ddr_ba;
    logic [ROW_W-1:0]  ddr_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int m_op  [2][16];
    int m_ofs [2][16];
    int m_rep [2][16];
    int m_last[2];

    always #4 clk = ~clk;

    sdram_pattern_seq dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready),
        .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
        .ddr_ba(ddr_ba), .ddr_addr(ddr_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] bus_word(input logic [3:0] pins, input int ba, input int ad);
        logic [BANK_W-1:0] b;
        logic [ROW_W-1:0]  a;
        b = BANK_W'(ba);
        a = ROW_W'(ad);
        return 32'({pins, b, a});
    endfunction

    function automatic logic [31:0] bus_now();
        return 32'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_ba, ddr_addr});
    endfunction

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = (SLOT_AW+2)'(a);
        cfg_wdata = EW'(d);
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic prog_slot(input int p, input int s, input int op, input int ofs, input int rep);
        cfg_write((p << SLOT_AW) | s, (op << (OFS_W + REP_W)) | (ofs << REP_W) | rep);
        m_op[p][s]  = op;
        m_ofs[p][s] = ofs;
        m_rep[p][s] = rep;
    endtask

    task automatic prog_last(input int p, input int l);
        cfg_write((1 << (SLOT_AW+1)) | p, l);
        m_last[p] = l;
    endtask

    task automatic run_req(input int wr, input int bank, input int row, input int col,
                           input int inj_cyc, input int inj_a, input int inj_d);
        int total;
        int cyc;
        int lane[4];
        total = 0;
        cyc   = 0;
        for (int o = 0; o < 4; o++) lane[o] = 0;
        for (int s = 0; s <= m_last[wr]; s++) total += m_rep[wr][s] + 1;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr[0];
        req_bank  = BANK_W'(bank);
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        check("R2 ready while idle", 32'(req_ready), 32'd1);
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check("R2 ready low after accept", 32'(req_ready), 32'd0);
        for (int s = 0; s <= m_last[wr]; s++) begin
            for (int k = 0; k <= m_rep[wr][s]; k++) begin
                logic [31:0] e;
                int b;
                @(negedge clk);
                e = bus_word(4'b0111, 0, 0);
                b = (bank + m_ofs[wr][s]) % NBANK;
                if (k == 0) begin
                    case (m_op[wr][s])
                        1: e = bus_word(4'b0011, b, row);
                        2: begin
                            e = bus_word(4'b0101, b, (col + lane[m_ofs[wr][s]] * BL) % NCOL);
                            lane[m_ofs[wr][s]]++;
                        end
                        3: begin
                            e = bus_word(4'b0100, b, (col + lane[m_ofs[wr][s]] * BL) % NCOL);
                            lane[m_ofs[wr][s]]++;
                        end
                        4: e = bus_word(4'b0010, b, 0);
                        default: e = bus_word(4'b0111, 0, 0);
                    endcase
                end
                check("R3 R4 R5 R6 R7 R8 command stream", bus_now(), e);
                cyc++;
                check("R2 ready during and after sequence", 32'(req_ready),
                      32'((cyc == total && inj_cyc < 0) ? 1 : 0));
                if (cyc - 1 == inj_cyc) begin
                    cfg_we    = 1'b1;
                    cfg_addr  = (SLOT_AW+2)'(inj_a);
                    cfg_wdata = EW'(inj_d);
                    fork
                        begin
                            @(posedge clk);
                            #1 cfg_we = 1'b0;
                        end
                    join_none
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cols[4];
        cols[0] = 0; cols[1] = 5; cols[2] = 1016; cols[3] = 1023;
        for (int p = 0; p < 2; p++) begin
            m_last[p] = 0;
            for (int s = 0; s < 16; s++) begin
                m_op[p][s] = 0; m_ofs[p][s] = 0; m_rep[p][s] = 0;
            end
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 idle bus after reset", bus_now(), bus_word(4'b0111, 0, 0));
        check("R1 req_ready after reset", 32'(req_ready), 32'd1);
        check("R1 cfg_ready after reset", 32'(cfg_ready), 32'd1);
        // R11 default table: one idle cycle per request
        run_req(0, 3, 7, 9, -1, 0, 0);
        run_req(1, 5, 7, 9, -1, 0, 0);

        // R9 read table: two banks interleaved, four bursts each
        prog_slot(0, 0, 1, 0, 2);
        prog_slot(0, 1, 2, 0, 3);
        prog_slot(0, 2, 2, 0, 1);
        prog_slot(0, 3, 1, 1, 0);
        prog_slot(0, 4, 2, 0, 3);
        prog_slot(0, 5, 2, 0, 2);
        prog_slot(0, 6, 2, 1, 3);
        prog_slot(0, 7, 2, 1, 3);
        prog_slot(0, 8, 2, 1, 3);
        prog_slot(0, 9, 2, 1, 0);
        prog_slot(0, 10, 0, 0, 5);
        prog_slot(0, 11, 4, 0, 1);
        prog_slot(0, 12, 4, 1, 0);
        prog_last(0, 12);
        // R9 write table: four banks interleaved, one burst each, plus a second burst on offset 2
        prog_slot(1, 0, 1, 0, 1);
        prog_slot(1, 1, 1, 1, 1);
        prog_slot(1, 2, 1, 2, 1);
        prog_slot(1, 3, 1, 3, 1);
        prog_slot(1, 4, 3, 0, 3);
        prog_slot(1, 5, 3, 1, 3);
        prog_slot(1, 6, 3, 2, 3);
        prog_slot(1, 7, 3, 3, 3);
        prog_slot(1, 8, 3, 2, 0);
        prog_slot(1, 9, 0, 0, 15);
        prog_slot(1, 10, 4, 3, 0);
        prog_last(1, 10);

        // R5 R7 R8 sweep of first bank, column and direction
        for (int b = 0; b < NBANK; b++) begin
            for (int c = 0; c < 4; c++) begin
                for (int w = 0; w < 2; w++) begin
                    run_req(w, b, (b * 1117 + c * 313 + w) % (1 << ROW_W), cols[c], -1, 0, 0);
                end
            end
        end

        // R10 held rewrite: turn read slot 11 into unused code 7 (R4 idle) mid-sequence
        run_req(0, 6, 100, 1020, 5, 11, (7 << (OFS_W + REP_W)) | 1);
        check("R10 cfg_ready low while held", 32'(cfg_ready), 32'd0);
        @(negedge clk);
        check("R10 req_ready back after release", 32'(req_ready), 32'd1);
        check("R10 cfg_ready back after release", 32'(cfg_ready), 32'd1);
        m_op[0][11] = 7;
        run_req(0, 7, 55, 8, -1, 0, 0);
        run_req(1, 7, 55, 8, -1, 0, 0);

        // R3 shortened read sequence via last index
        prog_last(0, 3);
        run_req(0, 2, 9, 17, -1, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule